// File: doc/BRIEF.md
# 128-bit Lane Permutation Unit

This block rearranges the lanes of two 128-bit vector operands. Operand A stands for the destination register's old contents and operand B for the second source. A 4-bit operation code picks one of these operations:

- immediate-driven shuffles with one or two sources, at 16-, 32- and 64-bit lane size;
- low-half and high-half interleaves at 8-, 16-, 32- and 64-bit element size;
- extraction of the sign bit of each 32-bit or 64-bit lane into a small mask.

An 8-bit immediate steers the shuffles. The interleaves and mask operations ignore it.

A request is accepted when `in_valid` is high at a rising clock edge. The operands, code and immediate are captured at that edge. The result appears on the outputs in the following cycle, with `out_valid` high for that one cycle. Permutation results come out on `out_result`, and sign masks come out on `out_mask`, zero-extended. The unit has no back-pressure: a new request can be issued every cycle.

Top module: `simd_perm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid`, `out_illegal`, `out_result` and `out_mask` all zero.
- R2: A request sampled with `in_valid` high produces `out_valid` high in the next cycle only. Operands are captured only when `in_valid` is high, so the outputs hold while `in_valid` is low.
- R3: Code 0 (two-source dword shuffle): result dword k takes dword imm[2k+1:2k] of A for k=0,1, and dword imm[2k+1:2k] of B for k=2,3.
- R4: Code 1 (two-source qword shuffle): result bits 63:0 take A's qword selected by imm[0]; result bits 127:64 take B's qword selected by imm[1]; imm[7:2] has no effect.
- R5: Code 2 (single-source dword shuffle): result dword k is dword imm[2k+1:2k] of B, for k=0..3.
- R6: Code 3 (upper word shuffle): result word 4+k is word 4+imm[2k+1:2k] of B; result bits 63:0 equal B bits 63:0.
- R7: Code 4 (lower word shuffle): result word k is word imm[2k+1:2k] of B; result bits 127:64 equal B bits 127:64.
- R8: Codes 5, 6, 7 (low interleave at 8, 16, 32 bits): with N elements per vector and i < N/2, result element 2i is A element i and element 2i+1 is B element i.
- R9: Codes 9, 10, 11 (high interleave at 8, 16, 32 bits): result element 2i is A element i+N/2 and element 2i+1 is B element i+N/2.
- R10: Code 8 gives {B[63:0], A[63:0]}; code 12 gives {B[127:64], A[127:64]}.
- R11: Code 13: `out_mask[3:0]` holds B bits 127, 95, 63, 31 (bit 3 down to bit 0). The other mask bits and `out_result` are zero.
- R12: Code 14: `out_mask[1]` is B bit 127 and `out_mask[0]` is B bit 63. The other mask bits and `out_result` are zero.
- R13: Code 15 is illegal: `out_illegal` is high and both `out_result` and `out_mask` are zero. Every other code gives `out_illegal` low, and every code except 13 and 14 gives `out_mask` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures the inputs |
| in_op | input | 4 | Operation code |
| in_imm | input | 8 | Shuffle immediate |
| in_a | input | 128 | Operand A (destination's old value) |
| in_b | input | 128 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 128 | Permuted vector |
| out_mask | output | 32 | Sign mask, zero-extended |
| out_illegal | output | 1 | Code 15 was requested |

## Verification
The bench sweeps all 256 immediates for every shuffle code, using operands whose bytes each carry their own index. Any lane fed from the wrong index, the wrong source or the wrong half therefore shows up as a wrong byte value.

The two-source shuffles are where a source swap is most likely: a design that took the upper dwords from A instead of B would fail on nearly every immediate. The word shuffles are checked for the untouched half, since a design that permuted the wrong half, or zeroed the pass-through half, breaks R6 and R7.

The interleaves are checked at every element size and for both halves. An element order of B before A, or a wrong half-offset, gives a mismatch. The sign masks are driven with alternating and all-ones sign patterns so that bit-order reversal is caught.

The illegal code and the hold behaviour with `in_valid` low are also checked.

// File: rtl/simd_perm_pkg.sv
// Package: shared widths and operation codes of the lane permutation unit.
// Assumes a 128-bit vector whose 2-bit immediate fields address four lanes.
package simd_perm_pkg;
    localparam int VEC_W  = 128;
    localparam int IMM_W  = 8;
    localparam int MASK_W = 32;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF32_AB = 4'd0,
        OP_SHUF64_AB = 4'd1,
        OP_SHUF32_B  = 4'd2,
        OP_SHUF16_HI = 4'd3,
        OP_SHUF16_LO = 4'd4,
        OP_ILV_LO8   = 4'd5,
        OP_ILV_LO16  = 4'd6,
        OP_ILV_LO32  = 4'd7,
        OP_ILV_LO64  = 4'd8,
        OP_ILV_HI8   = 4'd9,
        OP_ILV_HI16  = 4'd10,
        OP_ILV_HI32  = 4'd11,
        OP_ILV_HI64  = 4'd12,
        OP_SIGN_PS   = 4'd13,
        OP_SIGN_PD   = 4'd14
    } perm_op_e;
endpackage

// File: rtl/perm_shuffle.sv
// Module: immediate-controlled shuffles (dword two-source, qword two-source,
// dword single-source, word upper/lower half). Purely combinational.
// Assumes VEC_W splits into four dwords and eight words.
module perm_shuffle #(
    parameter int VEC_W = simd_perm_pkg::VEC_W,
    parameter int IMM_W = simd_perm_pkg::IMM_W
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [IMM_W-1:0] imm,
    output logic [VEC_W-1:0] shuf32_ab,
    output logic [VEC_W-1:0] shuf64_ab,
    output logic [VEC_W-1:0] shuf32_b,
    output logic [VEC_W-1:0] shuf16_hi,
    output logic [VEC_W-1:0] shuf16_lo
);
    localparam int LANES = 4;
    localparam int DW    = VEC_W / LANES;
    localparam int HALF  = VEC_W / 2;
    localparam int WW    = HALF / LANES;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [1:0] sel;
        assign sel = imm[2*l +: 2];
        // Lower two dwords draw from A, upper two from B.
        if (l < LANES/2) begin : g_from_a
            assign shuf32_ab[l*DW +: DW] = a[sel*DW +: DW];
        end else begin : g_from_b
            assign shuf32_ab[l*DW +: DW] = b[sel*DW +: DW];
        end
        assign shuf32_b[l*DW +: DW]         = b[sel*DW +: DW];
        assign shuf16_lo[l*WW +: WW]        = b[sel*WW +: WW];
        assign shuf16_hi[HALF + l*WW +: WW] = b[HALF + sel*WW +: WW];
    end

    // Word shuffles pass the opposite half straight through.
    assign shuf16_lo[VEC_W-1:HALF] = b[VEC_W-1:HALF];
    assign shuf16_hi[HALF-1:0]     = b[HALF-1:0];

    // Qword shuffle: imm[0] picks from A, imm[1] picks from B.
    assign shuf64_ab[HALF-1:0]     = imm[0] ? a[VEC_W-1:HALF] : a[HALF-1:0];
    assign shuf64_ab[VEC_W-1:HALF] = imm[1] ? b[VEC_W-1:HALF] : b[HALF-1:0];
endmodule

// File: rtl/perm_interleave.sv
// Module: low and high interleaves at every element size from MIN_ELEM up to
// half the vector. Index g of each output array is element size MIN_ELEM<<g.
// Assumes VEC_W is MIN_ELEM times a power of two.
module perm_interleave #(
    parameter int VEC_W    = simd_perm_pkg::VEC_W,
    parameter int MIN_ELEM = 8,
    parameter int NUM_GRAN = 4
) (
    input  logic [VEC_W-1:0]                a,
    input  logic [VEC_W-1:0]                b,
    output logic [NUM_GRAN-1:0][VEC_W-1:0]  ilv_lo,
    output logic [NUM_GRAN-1:0][VEC_W-1:0]  ilv_hi
);
    for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
        localparam int E = MIN_ELEM << g;
        localparam int N = VEC_W / E;
        for (genvar i = 0; i < N/2; i++) begin : g_elem
            // A's element lands first, B's element right after it.
            assign ilv_lo[g][(2*i)*E   +: E] = a[i*E +: E];
            assign ilv_lo[g][(2*i+1)*E +: E] = b[i*E +: E];
            assign ilv_hi[g][(2*i)*E   +: E] = a[(i+N/2)*E +: E];
            assign ilv_hi[g][(2*i+1)*E +: E] = b[(i+N/2)*E +: E];
        end
    end
endmodule

// File: rtl/perm_signmask.sv
// Module: gathers the sign bit of each dword and of each qword of B into
// zero-extended masks. Assumes MASK_W is at least four.
module perm_signmask #(
    parameter int VEC_W  = simd_perm_pkg::VEC_W,
    parameter int MASK_W = simd_perm_pkg::MASK_W
) (
    input  logic [VEC_W-1:0]  b,
    output logic [MASK_W-1:0] mask_ps,
    output logic [MASK_W-1:0] mask_pd
);
    localparam int NDW = 4;
    localparam int NQW = 2;
    localparam int DW  = VEC_W / NDW;
    localparam int QW  = VEC_W / NQW;

    logic unused_b;
    assign unused_b = ^b;

    for (genvar d = 0; d < NDW; d++) begin : g_ps
        assign mask_ps[d] = b[d*DW + DW - 1];
    end
    assign mask_ps[MASK_W-1:NDW] = '0;

    for (genvar q = 0; q < NQW; q++) begin : g_pd
        assign mask_pd[q] = b[q*QW + QW - 1];
    end
    assign mask_pd[MASK_W-1:NQW] = '0;
endmodule

// File: rtl/simd_perm_unit.sv
// Module: top of the lane permutation unit. Captures a request on in_valid,
// then presents the chosen permutation or sign mask one cycle later.
// Assumes one request per cycle at most; no back-pressure.
module simd_perm_unit
    import simd_perm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [VEC_W-1:0]   in_a,
    input  logic [VEC_W-1:0]   in_b,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_result,
    output logic [MASK_W-1:0]  out_mask,
    output logic               out_illegal
);
    localparam int NUM_GRAN = 4;

    logic [OP_W-1:0]  op_q;
    logic [IMM_W-1:0] imm_q;
    logic [VEC_W-1:0] a_q, b_q;
    logic             vld_q;

    // Operand capture, gated by the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            imm_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (in_valid) begin
            op_q  <= in_op;
            imm_q <= in_imm;
            a_q   <= in_a;
            b_q   <= in_b;
        end
    end

    // Valid pipeline stage, one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_valid;
    end

    logic [VEC_W-1:0] s32ab, s64ab, s32b, s16hi, s16lo;
    logic [NUM_GRAN-1:0][VEC_W-1:0] ilo, ihi;
    logic [MASK_W-1:0] m_ps, m_pd;

    perm_shuffle #(.VEC_W(VEC_W), .IMM_W(IMM_W)) u_shuf (
        .a(a_q), .b(b_q), .imm(imm_q),
        .shuf32_ab(s32ab), .shuf64_ab(s64ab), .shuf32_b(s32b),
        .shuf16_hi(s16hi), .shuf16_lo(s16lo)
    );

    perm_interleave #(.VEC_W(VEC_W), .MIN_ELEM(8), .NUM_GRAN(NUM_GRAN)) u_ilv (
        .a(a_q), .b(b_q), .ilv_lo(ilo), .ilv_hi(ihi)
    );

    perm_signmask #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_sign (
        .b(b_q), .mask_ps(m_ps), .mask_pd(m_pd)
    );

    // Output selection by operation code; unlisted codes are illegal.
    always_comb begin
        out_result  = '0;
        out_mask    = '0;
        out_illegal = 1'b0;
        case (op_q)
            OP_SHUF32_AB: out_result = s32ab;
            OP_SHUF64_AB: out_result = s64ab;
            OP_SHUF32_B:  out_result = s32b;
            OP_SHUF16_HI: out_result = s16hi;
            OP_SHUF16_LO: out_result = s16lo;
            OP_ILV_LO8:   out_result = ilo[0];
            OP_ILV_LO16:  out_result = ilo[1];
            OP_ILV_LO32:  out_result = ilo[2];
            OP_ILV_LO64:  out_result = ilo[3];
            OP_ILV_HI8:   out_result = ihi[0];
            OP_ILV_HI16:  out_result = ihi[1];
            OP_ILV_HI32:  out_result = ihi[2];
            OP_ILV_HI64:  out_result = ihi[3];
            OP_SIGN_PS:   out_mask   = m_ps;
            OP_SIGN_PD:   out_mask   = m_pd;
            default:      out_illegal = 1'b1;
        endcase
    end

    assign out_valid = vld_q;
endmodule

// File: rtl/simd_perm_checker.sv
// Module: temporal properties of the lane permutation unit, observed at its
// ports. Attached by bind below. Assumes default widths.
module simd_perm_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   in_op,
    input logic [127:0] in_a,
    input logic [127:0] in_b,
    input logic         out_valid,
    input logic [127:0] out_result,
    input logic [31:0]  out_mask,
    input logic         out_illegal
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_illegal && out_result == '0 && out_mask == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HI16_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd3) |=> out_result[63:0] == $past(in_b[63:0])); // R6
    AST_LO16_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd4) |=> out_result[127:64] == $past(in_b[127:64])); // R7
    AST_QILV_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd8) |=> out_result == {$past(in_b[63:0]), $past(in_a[63:0])}); // R10
    AST_PS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd13) |=> (out_mask == {28'd0, $past(in_b[127]), $past(in_b[95]),
                                          $past(in_b[63]), $past(in_b[31])} && out_result == '0)); // R11
    AST_PD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd14) |=> out_mask == {30'd0, $past(in_b[127]), $past(in_b[63])}); // R12
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_illegal == ($past(in_op) == 4'd15))); // R13
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0 && out_mask == '0)); // R13
endmodule

bind simd_perm_unit simd_perm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_mask(out_mask), .out_illegal(out_illegal)
);

// File: tb/tb_simd_perm_unit.sv
`timescale 1ns/1ps
module tb_simd_perm_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [7:0]   in_imm = '0;
    logic [127:0] in_a = '0, in_b = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic [31:0]  out_mask;
    logic         out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simd_perm_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_imm(in_imm), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_mask(out_mask), .out_illegal(out_illegal)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5, 4'd6, 4'd7: return "R8";
            4'd9, 4'd10, 4'd11: return "R9";
            4'd8, 4'd12: return "R10";
            4'd13: return "R11";
            4'd14: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Expected vector, built from the requirement text.
    function automatic logic [127:0] exp_result(input logic [3:0] op, input logic [7:0] imm,
                                                input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        int e, n, base;
        case (op)
            4'd0: for (int k = 0; k < 4; k++) begin
                      int s = (imm >> (2*k)) & 3;
                      if (k < 2) r[k*32 +: 32] = a[s*32 +: 32];
                      else       r[k*32 +: 32] = b[s*32 +: 32];
                  end
            4'd1: begin
                      r[63:0]   = imm[0] ? a[127:64] : a[63:0];
                      r[127:64] = imm[1] ? b[127:64] : b[63:0];
                  end
            4'd2: for (int k = 0; k < 4; k++) begin
                      int s = (imm >> (2*k)) & 3;
                      r[k*32 +: 32] = b[s*32 +: 32];
                  end
            4'd3: begin
                      r[63:0] = b[63:0];
                      for (int k = 0; k < 4; k++) begin
                          int s = (imm >> (2*k)) & 3;
                          r[64 + k*16 +: 16] = b[64 + s*16 +: 16];
                      end
                  end
            4'd4: begin
                      r[127:64] = b[127:64];
                      for (int k = 0; k < 4; k++) begin
                          int s = (imm >> (2*k)) & 3;
                          r[k*16 +: 16] = b[s*16 +: 16];
                      end
                  end
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12: begin
                      e = 8 << ((op - 5) % 4);
                      n = 128 / e;
                      base = (op >= 9) ? n/2 : 0;
                      for (int i = 0; i < n/2; i++)
                          for (int t = 0; t < e; t++) begin
                              r[(2*i)*e + t]   = a[(i+base)*e + t];
                              r[(2*i+1)*e + t] = b[(i+base)*e + t];
                          end
                  end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] op, input logic [127:0] b);
        logic [31:0] m = '0;
        if (op == 4'd13) m[3:0] = {b[127], b[95], b[63], b[31]};
        if (op == 4'd14) m[1:0] = {b[127], b[63]};
        return m;
    endfunction

    task automatic issue(input logic [3:0] op, input logic [7:0] imm,
                         input logic [127:0] a, input logic [127:0] b);
        logic [127:0] er;
        logic [31:0]  em;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_imm = imm; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        er = exp_result(op, imm, a, b);
        em = exp_mask(op, b);
        check(out_valid == 1'b1, "R2 valid", {127'd0, out_valid}, 128'd1);
        check(out_result == er, op_tag(op), out_result, er);
        check(out_mask == em, op_tag(op), {96'd0, out_mask}, {96'd0, em});
        check(out_illegal == (op == 4'd15), "R13 flag", {127'd0, out_illegal},
              {127'd0, (op == 4'd15)});
    endtask

    function automatic logic [127:0] pattern(input int p, input bit is_b);
        logic [127:0] v;
        case (p)
            0: for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(k) | (is_b ? 8'h80 : 8'h40);
            1: v = is_b ? {4{32'h8000_0001}} ^ 128'h8000_0000_0000_0000_0000_0000_0000_0000
                        : {4{32'h1234_5678}};
            2: v = is_b ? {32'h8000_0000, 32'h0, 32'h0, 32'h7fff_ffff} : ~128'd0;
            default: v = {$urandom, $urandom, $urandom, $urandom};
        endcase
        return v;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R1: outputs quiet after reset.
        check(out_valid == 1'b0 && out_illegal == 1'b0, "R1 flags",
              {126'd0, out_valid, out_illegal}, 128'd0);
        check(out_result == '0 && out_mask == '0, "R1 data", out_result | {96'd0, out_mask}, 128'd0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 16; op++)
                if (op <= 4) begin
                    for (int imm = 0; imm < 256; imm++)
                        issue(4'(op), 8'(imm), pattern(p, 1'b0), pattern(p, 1'b1));
                end else begin
                    for (int imm = 0; imm < 256; imm += 51)
                        issue(4'(op), 8'(imm), pattern(p, 1'b0), pattern(p, 1'b1));
                end

        // R2: inputs with in_valid low leave the outputs unchanged.
        issue(4'd0, 8'h1B, pattern(0, 1'b0), pattern(0, 1'b1));
        held = out_result;
        in_a = ~in_a; in_b = ~in_b; in_op = 4'd15; in_imm = 8'hFF;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 drop", {127'd0, out_valid}, 128'd0);
        check(out_result == held && out_illegal == 1'b0, "R2 hold", out_result, held);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule